// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Decoder

This block sits between a host I/O bus and the rest of the chip. It watches every host I/O cycle and turns accesses to a pair of dword ports into PCI configuration requests. The first port is a 32-bit selector register at I/O address 0CF8h. Software writes it with a value that names a bus, a device, a function and a dword register index, and sets an enable bit. A later read or write of the 32-bit data window at 0CFCh-0CFFh then becomes one configuration transfer to that register. The transfer goes out on a request/response port toward the configuration fabric.

The selector is only claimed by a full-dword access to 0CF8h with all four byte enables set. Narrower accesses that touch 0CF8h-0CFBh are handed to the ordinary I/O forwarding port. This matters because a separate byte-wide reset-control register lives at 0CF9h. Data-window accesses made while the enable bit is clear, and all other addresses, go the same way.

Each host access is a one-cycle strobe. The block answers with a one-cycle ready pulse once the downstream side has completed the access, and it keeps at most one request outstanding.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write to address 0CF8h with byte enables 1111 stores the write data into the selector with bits 30:24 and 1:0 forced to zero. A read with the same address and enables returns the stored selector value.
- R2: An access to 0CF8h-0CFBh whose address is not exactly 0CF8h, or whose byte enables are not 1111, leaves the selector unchanged. It is forwarded on the I/O port with its address, enables and data unchanged; this covers a byte write to 0CF9h with enables 0010.
- R3: While selector bit 31 is set, an access to 0CFCh-0CFFh with at least one byte enable set raises a configuration request. The request carries bus = selector bits 23:16, device = bits 15:11, function = bits 10:8, register index = bits 7:2, and the host's byte enables, write flag and write data.
- R4: The configuration request's type flag is 0 when the requested bus number is zero and 1 otherwise.
- R5: A data-window access with byte enables 0000 while selector bit 31 is set raises no request of any kind. It completes on the next cycle, and a read returns FFFFFFFFh.
- R6: While selector bit 31 is clear, data-window accesses are forwarded on the I/O port and raise no configuration request.
- R7: A configuration read that completes with the abort flag set returns FFFFFFFFh to the host. A configuration write that completes with abort still completes normally toward the host.
- R8: A configuration or I/O request stays asserted with stable fields until its done input is seen. Ready rises for exactly one cycle, on the cycle after done. At most one of the two requests is asserted at a time.
- R9: After reset the selector reads as zero, no request is asserted and ready is low.
- R10: Accesses to any other address are forwarded on the I/O port unchanged, and a forwarded read returns the I/O port's read data.
- R11: Write completions return read data zero. Read data is zero in every cycle in which ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | IO_AW | Host I/O byte address |
| h_be | input | 4 | Host byte enables |
| h_rd | input | 1 | One-cycle read strobe |
| h_wr | input | 1 | One-cycle write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read data, valid with ready |
| h_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request, held until done |
| cfg_we | output | 1 | Configuration write when high |
| cfg_type1 | output | 1 | Type flag, 1 for a non-zero bus |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables of the transfer |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Configuration response strobe |
| cfg_abort | input | 1 | No target answered, valid with done |
| cfg_rdata | input | 32 | Configuration read data, valid with done |
| io_req | output | 1 | Forwarded I/O request, held until done |
| io_we | output | 1 | Forwarded I/O write when high |
| io_addr | output | IO_AW | Forwarded I/O address |
| io_be | output | 4 | Forwarded byte enables |
| io_wdata | output | 32 | Forwarded write data |
| io_done | input | 1 | I/O response strobe |
| io_rdata | input | 32 | I/O read data, valid with done |

## Verification
The hardest cases to reach from the ports are the ones where the result depends on what the selector held when the data-window access arrived. Examples are a data-window access after a narrow write that overlapped 0CF8h, and a window access made while the enable bit is clear. The stimulus therefore runs sequences of selector writes, narrow overlapping writes and window accesses. A behavioural model tracks the selector and predicts which port each access must reach. The bench's downstream responders use programmable latency and abort, so that long waits and aborted reads and writes are covered as well.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int DW = 32;
    localparam int BEW = DW / 8;
    localparam logic [DW-1:0] SEL_KEEP_MASK = 32'h80FF_FFFC;
    localparam logic [DW-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic       en;
        logic [6:0] rsvd;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] idx;
        logic [1:0] lo;
    } cfg_sel_t;

    typedef enum logic [1:0] {
        K_SEL  = 2'd0,
        K_CFG  = 2'd1,
        K_NULL = 2'd2,
        K_IO   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CFG  = 2'd1,
        S_IO   = 2'd2,
        S_RESP = 2'd3
    } ctl_state_e;

    function automatic cfg_sel_t sel_clean(input logic [DW-1:0] v);
        return cfg_sel_t'(v & SEL_KEEP_MASK);
    endfunction

    function automatic logic bus_is_remote(input logic [7:0] b);
        return (b != 8'd0);
    endfunction

endpackage

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
    import cfgdec_pkg::*;
#(
    parameter int              IO_AW     = 16,
    parameter logic [IO_AW-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] WIN_PORT = 16'h0CFC
) (
    input  logic [IO_AW-1:0] addr,
    input  logic [BEW-1:0]   be,
    input  logic             sel_en,
    output acc_kind_e        kind
);
    localparam int LSB = $clog2(BEW);

    logic sel_hit;
    logic win_hit;

    always_comb begin
        sel_hit = (addr == SEL_PORT) && (be == {BEW{1'b1}});
        win_hit = (addr[IO_AW-1:LSB] == WIN_PORT[IO_AW-1:LSB]) && sel_en;
        if (sel_hit)
            kind = K_SEL;
        else if (win_hit && (be == '0))
            kind = K_NULL;
        else if (win_hit)
            kind = K_CFG;
        else
            kind = K_IO;
    end
endmodule

// File: rtl/cfgdec_sel_reg.sv
module cfgdec_sel_reg
    import cfgdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output cfg_sel_t      sel
);
    cfg_sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (we)
            sel_q <= sel_clean(wdata);
    end

    assign sel = sel_q;

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        we |=> (sel.rsvd == '0) && (sel.lo == '0));
endmodule

// File: rtl/cfgdec_ctrl.sv
module cfgdec_ctrl
    import cfgdec_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [IO_AW-1:0] acc_addr,
    input  logic [BEW-1:0]   acc_be,
    input  logic [DW-1:0]    acc_wdata,
    input  acc_kind_e        kind,
    input  cfg_sel_t         sel,
    output logic             sel_we,
    output logic [DW-1:0]    h_rdata,
    output logic             h_ready,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic             cfg_type1,
    output logic [7:0]       cfg_bus,
    output logic [4:0]       cfg_dev,
    output logic [2:0]       cfg_fn,
    output logic [5:0]       cfg_reg,
    output logic [BEW-1:0]   cfg_be,
    output logic [DW-1:0]    cfg_wdata,
    input  logic             cfg_done,
    input  logic             cfg_abort,
    input  logic [DW-1:0]    cfg_rdata,
    output logic             io_req,
    output logic             io_we,
    output logic [IO_AW-1:0] io_addr,
    output logic [BEW-1:0]   io_be,
    output logic [DW-1:0]    io_wdata,
    input  logic             io_done,
    input  logic [DW-1:0]    io_rdata
);
    ctl_state_e      state_q;
    logic [DW-1:0]   rdata_q;
    logic            start;

    assign start  = (state_q == S_IDLE) && (acc_rd || acc_wr);
    assign sel_we = start && acc_wr && (kind == K_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            rdata_q   <= '0;
            cfg_we    <= 1'b0;
            cfg_type1 <= 1'b0;
            cfg_bus   <= '0;
            cfg_dev   <= '0;
            cfg_fn    <= '0;
            cfg_reg   <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            io_we     <= 1'b0;
            io_addr   <= '0;
            io_be     <= '0;
            io_wdata  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    rdata_q <= '0;
                    if (start) begin
                        unique case (kind)
                            K_SEL: begin
                                rdata_q <= acc_wr ? '0 : DW'(sel);
                                state_q <= S_RESP;
                            end
                            K_NULL: begin
                                rdata_q <= acc_wr ? '0 : ALL_ONES;
                                state_q <= S_RESP;
                            end
                            K_CFG: begin
                                cfg_we    <= acc_wr;
                                cfg_type1 <= bus_is_remote(sel.bus);
                                cfg_bus   <= sel.bus;
                                cfg_dev   <= sel.dev;
                                cfg_fn    <= sel.fn;
                                cfg_reg   <= sel.idx;
                                cfg_be    <= acc_be;
                                cfg_wdata <= acc_wdata;
                                state_q   <= S_CFG;
                            end
                            default: begin
                                io_we    <= acc_wr;
                                io_addr  <= acc_addr;
                                io_be    <= acc_be;
                                io_wdata <= acc_wdata;
                                state_q  <= S_IO;
                            end
                        endcase
                    end
                end
                S_CFG: begin
                    if (cfg_done) begin
                        if (cfg_we)
                            rdata_q <= '0;
                        else
                            rdata_q <= cfg_abort ? ALL_ONES : cfg_rdata;
                        state_q <= S_RESP;
                    end
                end
                S_IO: begin
                    if (io_done) begin
                        rdata_q <= io_we ? '0 : io_rdata;
                        state_q <= S_RESP;
                    end
                end
                default: begin
                    rdata_q <= '0;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    assign h_ready = (state_q == S_RESP);
    assign h_rdata = rdata_q;
    assign cfg_req = (state_q == S_CFG);
    assign io_req  = (state_q == S_IO);

    p_cfg_held_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_done) |=> cfg_req);
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_done) |=> ($stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_fn)
                                   && $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_we)));
    p_io_held_r8: assert property (@(posedge clk) disable iff (rst)
        (io_req && !io_done) |=> (io_req && $stable(io_addr)));
    p_one_req_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_req, io_req, h_ready}));
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        h_ready |=> !h_ready);
    p_type_bus_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_type1 == (cfg_bus != 8'd0)));
    p_be_live_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_be != '0));
    p_abort_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_done && cfg_abort && !cfg_we) |=> (h_ready && (h_rdata == ALL_ONES)));
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !h_ready |-> (h_rdata == '0));
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgdec_pkg::*;
#(
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] WIN_PORT = 16'h0CFC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] h_addr,
    input  logic [3:0]       h_be,
    input  logic             h_rd,
    input  logic             h_wr,
    input  logic [31:0]      h_wdata,
    output logic [31:0]      h_rdata,
    output logic             h_ready,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic             cfg_type1,
    output logic [7:0]       cfg_bus,
    output logic [4:0]       cfg_dev,
    output logic [2:0]       cfg_fn,
    output logic [5:0]       cfg_reg,
    output logic [3:0]       cfg_be,
    output logic [31:0]      cfg_wdata,
    input  logic             cfg_done,
    input  logic             cfg_abort,
    input  logic [31:0]      cfg_rdata,
    output logic             io_req,
    output logic             io_we,
    output logic [IO_AW-1:0] io_addr,
    output logic [3:0]       io_be,
    output logic [31:0]      io_wdata,
    input  logic             io_done,
    input  logic [31:0]      io_rdata
);
    cfg_sel_t  sel;
    acc_kind_e kind;
    logic      sel_we;

    cfgdec_classify #(
        .IO_AW(IO_AW), .SEL_PORT(SEL_PORT), .WIN_PORT(WIN_PORT)
    ) u_classify (
        .addr(h_addr), .be(h_be), .sel_en(sel.en), .kind(kind)
    );

    cfgdec_sel_reg u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .wdata(h_wdata), .sel(sel)
    );

    cfgdec_ctrl #(.IO_AW(IO_AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .acc_rd(h_rd), .acc_wr(h_wr), .acc_addr(h_addr), .acc_be(h_be),
        .acc_wdata(h_wdata), .kind(kind), .sel(sel), .sel_we(sel_we),
        .h_rdata(h_rdata), .h_ready(h_ready),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_type1(cfg_type1),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_done(cfg_done), .cfg_abort(cfg_abort), .cfg_rdata(cfg_rdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata)
    );
endmodule

// File: tb/test_cfg_port_decoder.sv
module test_cfg_port_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] h_addr = '0;
    logic [3:0]  h_be = '0;
    logic        h_rd = 1'b0, h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic        cfg_req, cfg_we, cfg_type1;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_done = 1'b0, cfg_abort = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic        io_req, io_we;
    logic [15:0] io_addr;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        io_done = 1'b0;
    logic [31:0] io_rdata = '0;

    always #10 clk = ~clk;

    cfg_port_decoder i_cfg_port_decoder (.*);

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string tag = "R9";
    bit    live = 0;

    int          cfg_lat = 1, io_lat = 1;
    bit          abort_on = 0;
    logic [31:0] cfg_rsp = '0, io_rsp = '0;

    // behavioural model
    int          m_st = 0;        // 0 idle, 1 cfg, 2 io, 3 resp
    logic [31:0] m_sel = '0, m_rd = '0;
    logic        m_we = 0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_wd = '0;
    logic [15:0] m_addr = '0;
    logic [31:0] m_req_sel = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_sel = '0; m_rd = '0;
        end else begin
            case (m_st)
                0: begin
                    m_rd = '0;
                    if (h_rd || h_wr) begin
                        m_we = h_wr; m_be = h_be; m_wd = h_wdata; m_addr = h_addr;
                        if (h_addr == 16'h0CF8 && h_be == 4'hF) begin
                            m_rd = h_wr ? 32'h0 : m_sel;
                            if (h_wr) m_sel = h_wdata & 32'h80FF_FFFC;
                            m_st = 3;
                        end else if (h_addr >= 16'h0CFC && h_addr <= 16'h0CFF && m_sel[31]) begin
                            if (h_be == 0) begin
                                m_rd = h_wr ? 32'h0 : 32'hFFFF_FFFF;
                                m_st = 3;
                            end else begin
                                m_req_sel = m_sel;
                                m_st = 1;
                            end
                        end else m_st = 2;
                    end
                end
                1: if (cfg_done) begin
                    m_rd = m_we ? 32'h0 : (cfg_abort ? 32'hFFFF_FFFF : cfg_rdata);
                    m_st = 3;
                end
                2: if (io_done) begin
                    m_rd = m_we ? 32'h0 : io_rdata;
                    m_st = 3;
                end
                default: begin m_rd = '0; m_st = 0; end
            endcase
        end
    end

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk((m_st == 3) ? "R8" : "R9", "h_ready", 32'(h_ready), 32'(m_st == 3));
            chk((m_st == 3) ? tag : "R11", "h_rdata", h_rdata, m_rd);
            chk(tag, "cfg_req", 32'(cfg_req), 32'(m_st == 1));
            chk(tag, "io_req", 32'(io_req), 32'(m_st == 2));
            if (m_st == 1) begin
                chk(tag, "cfg_bus", 32'(cfg_bus), 32'(m_req_sel[23:16]));
                chk(tag, "cfg_dev", 32'(cfg_dev), 32'(m_req_sel[15:11]));
                chk(tag, "cfg_fn", 32'(cfg_fn), 32'(m_req_sel[10:8]));
                chk(tag, "cfg_reg", 32'(cfg_reg), 32'(m_req_sel[7:2]));
                chk(tag, "cfg_be", 32'(cfg_be), 32'(m_be));
                chk(tag, "cfg_we", 32'(cfg_we), 32'(m_we));
                chk("R4", "cfg_type1", 32'(cfg_type1), 32'(m_req_sel[23:16] != 0));
                if (m_we) chk(tag, "cfg_wdata", cfg_wdata, m_wd);
            end
            if (m_st == 2) begin
                chk(tag, "io_addr", 32'(io_addr), 32'(m_addr));
                chk(tag, "io_be", 32'(io_be), 32'(m_be));
                chk(tag, "io_we", 32'(io_we), 32'(m_we));
                if (m_we) chk(tag, "io_wdata", io_wdata, m_wd);
            end
        end
    end

    // downstream responders
    int cfg_cnt = 0, io_cnt = 0;
    always @(negedge clk) begin
        #1;
        if (cfg_done) begin cfg_done = 0; cfg_abort = 0; cfg_cnt = 0; end
        else if (cfg_req) begin
            cfg_cnt++;
            if (cfg_cnt >= cfg_lat) begin
                cfg_done = 1; cfg_abort = abort_on; cfg_rdata = cfg_rsp;
            end
        end
        if (io_done) begin io_done = 0; io_cnt = 0; end
        else if (io_req) begin
            io_cnt++;
            if (io_cnt >= io_lat) begin io_done = 1; io_rdata = io_rsp; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic acc(input string t, input logic [15:0] a, input logic [3:0] be,
                       input bit wr, input logic [31:0] wd);
        @(negedge clk); #2;
        tag = t;
        h_addr = a; h_be = be; h_wdata = wd; h_rd = !wr; h_wr = wr;
        @(negedge clk); #2;
        h_rd = 0; h_wr = 0;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        live = 1;
        acc("R9", 16'h0CF8, 4'hF, 0, 0);
        acc("R1", 16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF);
        acc("R1", 16'h0CF8, 4'hF, 0, 0);
        io_rsp = 32'h0000_00A5;
        acc("R2", 16'h0CF9, 4'b0010, 1, 32'h0000_0600);
        acc("R2", 16'h0CF8, 4'b0111, 0, 0);
        acc("R2", 16'h0CF8, 4'hF, 0, 0);
        acc("R2", 16'h0CFA, 4'hF, 1, 32'h1);
        acc("R6", 16'h0CF8, 4'hF, 1, 32'h0000_1914);
        io_rsp = 32'h5A5A_0001;
        acc("R6", 16'h0CFC, 4'hF, 0, 0);
        acc("R3", 16'h0CF8, 4'hF, 1, 32'h8000_1914);
        cfg_rsp = 32'h1234_5678; cfg_lat = 2;
        acc("R3", 16'h0CFC, 4'hF, 0, 0);
        acc("R4", 16'h0CF8, 4'hF, 1, 32'hFF07_F8FF);
        acc("R4", 16'h0CFC, 4'b0011, 1, 32'hCAFE_BEEF);
        acc("R3", 16'h0CFE, 4'b1100, 0, 0);
        acc("R5", 16'h0CFC, 4'b0000, 0, 0);
        acc("R5", 16'h0CFC, 4'b0000, 1, 32'h77);
        abort_on = 1;
        acc("R7", 16'h0CFC, 4'hF, 0, 0);
        acc("R7", 16'h0CFC, 4'hF, 1, 32'h55);
        abort_on = 0; cfg_lat = 20;
        acc("R8", 16'h0CFC, 4'b1000, 0, 0);
        io_lat = 7; io_rsp = 32'hDEAD_0080;
        acc("R10", 16'h0080, 4'b0001, 0, 0);
        acc("R10", 16'h0080, 4'b1111, 1, 32'h0102_0304);
        acc("R11", 16'h0CF8, 4'hF, 0, 0);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule